// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block translates a virtual address into a physical address by walking a radix page table held in memory. A request carries the virtual address, the kind of access (instruction fetch, data load or data store), the privilege state, the two status bits that control supervisor access to user pages and loads from execute-only pages, the root table page number and a paging mode. The walker works out the effective privilege. It checks the address for proper sign extension and then reads one page table entry per level over a simple request/response memory port. It ends with a physical address or a fault code.

The paging mode selects the number of levels, the width of each index field and the entry size. A walk may end on a superpage leaf above the last level. In that case the low page-number bits of the result come from the virtual address. Accessed and dirty bits are never written back: an entry that lacks a required bit faults. A memory read that reports an error gives an access fault. Every other failure gives a page fault. Both kinds are split by access type.

Top module: `pt_walker`

## Requirements
- R1: A request is taken only when `busy` is low and `startValid` is high. `busy` then stays high until the result is shown, and `doneValid` is a one-cycle pulse. Requests made while busy have no effect.
- R2: Fetches use the current privilege. Loads and stores use the previous privilege when `mprv` is set and `debugMode` is clear, and the current privilege otherwise (1 = supervisor, 0 = user).
- R3: `pageMode` 0 is bare mode. The result equals the virtual address, the fault code is 0 and no memory read is made.
- R4: In a paged mode, address bits from the top down to bit (12 + levels × index width − 1) must be all equal. If they are not, the walk ends in a page fault without any memory read.
- R5: Modes 1, 2 and 3 give 2 levels of 10-bit indices with 4-byte entries, 3 levels of 9 bits with 8-byte entries, and 4 levels of 9 bits with 8-byte entries. At level i the entry address is base + index × size, with the index taken from bit 12 + i × width. For 4-byte entries only the low 32 bits of the read data are used.
- R6: An entry with V set and R, W, X clear points to the next table. The new base is its page number (bits from 10 up) shifted left by 12. Such an entry at level 0 gives a page fault.
- R7: A page with U (bit 4) set faults in supervisor mode for a fetch, and for a data access when `sumBit` is clear. A page with U clear faults in user mode.
- R8: A leaf faults when V (bit 0) is clear, or when W (bit 2) is set with R (bit 1) clear.
- R9: A fetch needs X (bit 3). A load needs R, or X when `mxrBit` is set. A store needs both R and W.
- R10: A leaf at level i faults when the low i × index-width bits of its page number are not zero.
- R11: A leaf faults when A (bit 6) is clear, or when D (bit 7) is clear on a store.
- R12: On success, `resultAddr` is the page number with its low i × index-width bits taken from the virtual page number, shifted left by 12, with the 12-bit page offset of the virtual address added.
- R13: A read answered with `memRspErr` gives an access fault. `faultCode` is 0 on success, 1/2/3 for fetch/load/store page faults and 5/6/7 for fetch/load/store access faults.
- R14: `memReq` is held for exactly one cycle per entry read. At most one read is outstanding, and the walker waits any number of cycles for `memRspValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Request strobe |
| startVa | input | XLEN | Virtual address |
| startType | input | 2 | 0 fetch, 1 load, 2 store |
| curSup | input | 1 | Current privilege is supervisor |
| mprv | input | 1 | Data accesses use previous privilege |
| prevSup | input | 1 | Previous privilege is supervisor |
| debugMode | input | 1 | Core in debug mode |
| sumBit | input | 1 | Supervisor may access user data pages |
| mxrBit | input | 1 | Loads may read execute-only pages |
| pageMode | input | 2 | Paging mode (0 bare) |
| rootPpn | input | XLEN | Root table page number |
| busy | output | 1 | Walk in progress |
| doneValid | output | 1 | Result valid pulse |
| resultAddr | output | XLEN | Physical address |
| faultCode | output | 3 | Outcome code |
| memReq | output | 1 | Entry read request |
| memAddr | output | XLEN | Entry byte address |
| memRspValid | input | 1 | Read response valid |
| memRspErr | input | 1 | Read address not legal |
| memRspData | input | XLEN | Read data |

## Verification
The bench builds page tables in a sparse memory model and walks them under every permission rule. It covers each single-bit flaw: a missing A or D bit, W without R, a user page under SUM, an execute-only page under MXR, and the previous privilege taken while in debug mode. A walker that checked these in the wrong privilege, or ignored MXR or SUM, would report success where a page fault is due, or the reverse. Superpage leaves are tried both aligned and misaligned, since a walker that did not splice the page number would return the wrong frame, and one that skipped the alignment check would accept a bad mapping. A missing table entry at the first and third level must give an access fault and not a page fault. A non-canonical address must fault with no read at all. The 4-byte mode puts garbage in the upper data half so that a walker using the full word would follow the wrong page.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;

  localparam int LVL_W = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  // entry flag positions
  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_X = 3;
  localparam int PTE_U = 4;
  localparam int PTE_A = 6;
  localparam int PTE_D = 7;

  typedef struct packed {
    logic [2:0] levels;
    logic [3:0] idxBits;
    logic [1:0] pteShift;
  } mode_cfg_t;

  typedef struct packed {
    logic capture;
    logic stepDown;
    logic setBare;
    logic setLeaf;
    logic setPageFault;
    logic setAccessFault;
  } walk_strobe_t;

  typedef struct packed {
    logic bare;
    logic nonCanon;
    logic isTable;
    logic leafOk;
    logic lastLevel;
  } walk_status_t;

  function automatic mode_cfg_t decodeMode(input logic [1:0] m);
    mode_cfg_t c;
    case (m)
      2'd1:    c = '{levels: 3'd2, idxBits: 4'd10, pteShift: 2'd2};
      2'd2:    c = '{levels: 3'd3, idxBits: 4'd9,  pteShift: 2'd3};
      2'd3:    c = '{levels: 3'd4, idxBits: 4'd9,  pteShift: 2'd3};
      default: c = '{levels: 3'd0, idxBits: 4'd0,  pteShift: 2'd3};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pt_walker_ctrl.sv
`timescale 1ns/1ps
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic         memRspValid,
  input  logic         memRspErr,
  input  walk_status_t status,
  output walk_strobe_t strobe,
  output logic         memReq,
  output logic         busy,
  output logic         doneValid
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_REQ, S_WAIT, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      S_IDLE: begin
        if (startValid) begin
          strobe.capture = 1'b1;
          nextState      = S_CHECK;
        end
      end
      S_CHECK: begin
        if (status.bare) begin
          strobe.setBare = 1'b1;
          nextState      = S_DONE;
        end else if (status.nonCanon) begin
          strobe.setPageFault = 1'b1;
          nextState           = S_DONE;
        end else begin
          nextState = S_REQ;
        end
      end
      S_REQ: nextState = S_WAIT;
      S_WAIT: begin
        if (memRspValid) begin
          if (memRspErr) begin
            strobe.setAccessFault = 1'b1;
            nextState             = S_DONE;
          end else if (status.isTable && !status.lastLevel) begin
            strobe.stepDown = 1'b1;
            nextState       = S_REQ;
          end else if (status.leafOk) begin
            strobe.setLeaf = 1'b1;
            nextState      = S_DONE;
          end else begin
            strobe.setPageFault = 1'b1;
            nextState           = S_DONE;
          end
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign memReq    = (state == S_REQ);
  assign busy      = (state != S_IDLE);
  assign doneValid = (state == S_DONE);

endmodule

// File: rtl/pt_walker_dpath.sv
`timescale 1ns/1ps
module pt_walker_dpath
  import pt_walker_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12,
  parameter int PPN_LSB  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  walk_strobe_t      strobe,
  input  logic [XLEN-1:0]   startVa,
  input  logic [1:0]        startType,
  input  logic              curSup,
  input  logic              mprv,
  input  logic              prevSup,
  input  logic              debugMode,
  input  logic              sumBit,
  input  logic              mxrBit,
  input  logic [1:0]        pageMode,
  input  logic [XLEN-1:0]   rootPpn,
  input  logic [XLEN-1:0]   memRspData,
  output walk_status_t      status,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   resultAddr,
  output logic [2:0]        faultCode
);

  localparam logic [XLEN-1:0] ONE      = 1;
  localparam logic [XLEN-1:0] OFF_MASK = (ONE << PG_SHIFT) - ONE;

  logic [XLEN-1:0]  vaReg, baseReg;
  logic [1:0]       typeReg, modeReg;
  logic             supReg, sumReg, mxrReg;
  logic [LVL_W-1:0] lvlReg;

  mode_cfg_t       cfg, startCfg;
  logic [XLEN-1:0] idxMask, lowMask, canonHi, canonMask;
  logic [XLEN-1:0] pte, ppn, vpn, leafAddr;
  int              idxShift, lowBits, vaBits;
  logic            isFetch, isLoad, isStore;
  logic            userBad, formBad, permBad, misal, adBad;
  logic [1:0]      typeCode;

  assign startCfg = decodeMode(pageMode);

  always_comb begin
    cfg       = decodeMode(modeReg);
    isFetch   = (typeReg == ACC_FETCH);
    isLoad    = (typeReg == ACC_LOAD);
    isStore   = !isFetch && !isLoad;
    typeCode  = isFetch ? 2'd1 : (isLoad ? 2'd2 : 2'd3);

    idxShift  = PG_SHIFT + int'(lvlReg) * int'(cfg.idxBits);
    idxMask   = (ONE << cfg.idxBits) - ONE;
    memAddr   = baseReg + (((vaReg >> idxShift) & idxMask) << cfg.pteShift);

    vaBits    = PG_SHIFT + int'(cfg.levels) * int'(cfg.idxBits);
    canonHi   = vaReg >> (vaBits - 1);
    canonMask = (ONE << (XLEN - vaBits + 1)) - ONE;

    pte       = (cfg.pteShift == 2'd2) ? {{(XLEN-32){1'b0}}, memRspData[31:0]} : memRspData;
    ppn       = pte >> PPN_LSB;
    vpn       = vaReg >> PG_SHIFT;
    lowBits   = int'(lvlReg) * int'(cfg.idxBits);
    lowMask   = (ONE << lowBits) - ONE;

    userBad   = pte[PTE_U] ? (supReg && (isFetch || !sumReg)) : !supReg;
    formBad   = !pte[PTE_V] || (!pte[PTE_R] && pte[PTE_W]);
    permBad   = isFetch ? !pte[PTE_X] :
                isLoad  ? !(pte[PTE_R] || (mxrReg && pte[PTE_X])) :
                          !(pte[PTE_R] && pte[PTE_W]);
    misal     = (ppn & lowMask) != '0;
    adBad     = !pte[PTE_A] || (isStore && !pte[PTE_D]);
    leafAddr  = ((ppn | (vpn & lowMask)) << PG_SHIFT) | (vaReg & OFF_MASK);

    status.bare      = (cfg.levels == 3'd0);
    status.nonCanon  = (canonHi != '0) && (canonHi != canonMask);
    status.isTable   = pte[PTE_V] && !pte[PTE_R] && !pte[PTE_W] && !pte[PTE_X];
    status.lastLevel = (lvlReg == '0);
    status.leafOk    = !status.isTable && !userBad && !formBad && !permBad && !misal && !adBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg      <= '0;
      baseReg    <= '0;
      typeReg    <= '0;
      modeReg    <= '0;
      supReg     <= 1'b0;
      sumReg     <= 1'b0;
      mxrReg     <= 1'b0;
      lvlReg     <= '0;
      resultAddr <= '0;
      faultCode  <= '0;
    end else begin
      if (strobe.capture) begin
        vaReg   <= startVa;
        typeReg <= startType;
        modeReg <= pageMode;
        supReg  <= (startType != ACC_FETCH && mprv && !debugMode) ? prevSup : curSup;
        sumReg  <= sumBit;
        mxrReg  <= mxrBit;
        baseReg <= rootPpn << PG_SHIFT;
        lvlReg  <= LVL_W'(startCfg.levels - 3'd1);
      end
      if (strobe.stepDown) begin
        baseReg <= ppn << PG_SHIFT;
        lvlReg  <= lvlReg - 1'b1;
      end
      if (strobe.setBare) begin
        resultAddr <= vaReg;
        faultCode  <= 3'd0;
      end
      if (strobe.setLeaf) begin
        resultAddr <= leafAddr;
        faultCode  <= 3'd0;
      end
      if (strobe.setPageFault)   faultCode <= {1'b0, typeCode};
      if (strobe.setAccessFault) faultCode <= {1'b1, typeCode};
    end
  end

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12,
  parameter int PPN_LSB  = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic [XLEN-1:0] startVa,
  input  logic [1:0]      startType,
  input  logic            curSup,
  input  logic            mprv,
  input  logic            prevSup,
  input  logic            debugMode,
  input  logic            sumBit,
  input  logic            mxrBit,
  input  logic [1:0]      pageMode,
  input  logic [XLEN-1:0] rootPpn,
  output logic            busy,
  output logic            doneValid,
  output logic [XLEN-1:0] resultAddr,
  output logic [2:0]      faultCode,
  output logic            memReq,
  output logic [XLEN-1:0] memAddr,
  input  logic            memRspValid,
  input  logic            memRspErr,
  input  logic [XLEN-1:0] memRspData
);

  walk_strobe_t strobe;
  walk_status_t status;

  pt_walker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .memRspValid(memRspValid), .memRspErr(memRspErr),
    .status(status), .strobe(strobe),
    .memReq(memReq), .busy(busy), .doneValid(doneValid)
  );

  pt_walker_dpath #(.XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .PPN_LSB(PPN_LSB)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startVa(startVa), .startType(startType),
    .curSup(curSup), .mprv(mprv), .prevSup(prevSup), .debugMode(debugMode),
    .sumBit(sumBit), .mxrBit(mxrBit), .pageMode(pageMode), .rootPpn(rootPpn),
    .memRspData(memRspData), .status(status), .memAddr(memAddr),
    .resultAddr(resultAddr), .faultCode(faultCode)
  );

endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            startValid,
  input logic [XLEN-1:0] startVa,
  input logic [1:0]      pageMode,
  input logic            busy,
  input logic            doneValid,
  input logic [XLEN-1:0] resultAddr,
  input logic [2:0]      faultCode,
  input logic            memReq,
  input logic            memRspValid,
  input logic            memRspErr
);

  logic [XLEN-1:0] chkVa;
  logic [1:0]      chkMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkVa   <= '0;
      chkMode <= 2'd1;
    end else if (startValid && !busy) begin
      chkVa   <= startVa;
      chkMode <= pageMode;
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> busy);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  p_bare_result_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && chkMode == 2'd0) |-> (resultAddr == chkVa && faultCode == 3'd0));

  p_bare_no_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && chkMode == 2'd0) |-> !memReq);

  p_err_access_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && memRspErr) |=> (doneValid && faultCode[2]));

  p_code_legal_r13: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (faultCode == 3'd0 || faultCode[1:0] != 2'd0));

  p_req_single_r14: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

endmodule

bind pt_walker pt_walker_chk #(.XLEN(XLEN)) i_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startVa(startVa),
  .pageMode(pageMode), .busy(busy), .doneValid(doneValid),
  .resultAddr(resultAddr), .faultCode(faultCode), .memReq(memReq),
  .memRspValid(memRspValid), .memRspErr(memRspErr)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  localparam int XLEN = 64;
  localparam logic [7:0] F_V = 8'h01, F_R = 8'h02, F_W = 8'h04, F_X = 8'h08,
                         F_U = 8'h10, F_A = 8'h40, F_D = 8'h80;
  localparam logic [63:0] VA39 = 64'h4040_3456;
  localparam logic [1:0] T_F = 2'd0, T_L = 2'd1, T_S = 2'd2;

  logic clk = 1'b0;
  logic rstN;
  logic startValid;
  logic [XLEN-1:0] startVa;
  logic [1:0] startType;
  logic curSup, mprv, prevSup, debugMode, sumBit, mxrBit;
  logic [1:0] pageMode;
  logic [XLEN-1:0] rootPpn;
  logic busy, doneValid, memReq;
  logic [XLEN-1:0] resultAddr, memAddr, memRspData;
  logic [2:0] faultCode;
  logic memRspValid, memRspErr;

  logic [63:0] ptMem [logic [63:0]];
  int checkCount = 0, failCount = 0;
  int reqCount = 0, protoErr = 0, rspDelay = 1, pendCnt = 0;
  logic [63:0] pendAddr;
  logic prevReq = 1'b0;
  logic [63:0] gotAddr;
  logic [2:0] gotFault;
  int gotReads;

  always #2.5 clk = ~clk;

  pt_walker #(.XLEN(XLEN)) i_pt_walker (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startVa(startVa),
    .startType(startType), .curSup(curSup), .mprv(mprv), .prevSup(prevSup),
    .debugMode(debugMode), .sumBit(sumBit), .mxrBit(mxrBit),
    .pageMode(pageMode), .rootPpn(rootPpn), .busy(busy), .doneValid(doneValid),
    .resultAddr(resultAddr), .faultCode(faultCode), .memReq(memReq),
    .memAddr(memAddr), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .memRspData(memRspData)
  );

  // memory model: answers rspDelay falling edges after the request
  initial begin
    memRspValid = 1'b0;
    memRspErr   = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memRspErr   = 1'b0;
      if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          memRspValid = 1'b1;
          if (ptMem.exists(pendAddr)) memRspData = ptMem[pendAddr];
          else begin
            memRspErr  = 1'b1;
            memRspData = '0;
          end
        end
      end
      if (memReq === 1'b1) begin
        if (prevReq || pendCnt > 0) protoErr++;
        pendAddr = memAddr;
        pendCnt  = rspDelay;
        reqCount++;
      end
      prevReq = memReq;
    end
  end

  function automatic logic [63:0] pteOf(input logic [63:0] ppn, input logic [7:0] fl);
    return (ppn << 10) | {56'd0, fl};
  endfunction

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic resetCtx();
    curSup = 1'b1; mprv = 1'b0; prevSup = 1'b0; debugMode = 1'b0;
    sumBit = 1'b0; mxrBit = 1'b0; rspDelay = 1;
  endtask

  task automatic chain39(input logic [63:0] leafPpn, input logic [7:0] fl);
    ptMem.delete();
    ptMem[64'h10_0008] = pteOf(64'h101, F_V);
    ptMem[64'h10_1010] = pteOf(64'h102, F_V);
    ptMem[64'h10_2018] = pteOf(leafPpn, fl);
  endtask

  task automatic runWalk(input logic [63:0] va, input logic [1:0] typ,
                         input logic [1:0] md, input logic [63:0] root);
    int waitCnt;
    @(negedge clk);
    reqCount   = 0;
    startVa    = va;
    startType  = typ;
    pageMode   = md;
    rootPpn    = root;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    waitCnt = 0;
    while (!doneValid && waitCnt < 300) begin
      @(negedge clk);
      waitCnt++;
    end
    gotAddr  = resultAddr;
    gotFault = faultCode;
    gotReads = reqCount;
    if (!doneValid) checkEq("R1 walk completes", 64'd0, 64'd1);
  endtask

  task automatic tReset();
    checkEq("R1 reset busy", {63'd0, busy}, 64'd0);
    checkEq("R1 reset done", {63'd0, doneValid}, 64'd0);
    checkEq("R14 reset memReq", {63'd0, memReq}, 64'd0);
  endtask

  task automatic tBare();
    resetCtx();
    runWalk(64'hDEAD_BEEF_1234_5678, T_L, 2'd0, 64'h100);
    checkEq("R3 bare addr", gotAddr, 64'hDEAD_BEEF_1234_5678);
    checkEq("R3 bare code", {61'd0, gotFault}, 64'd0);
    checkEq("R3 bare reads", 64'(gotReads), 64'd0);
  endtask

  task automatic tBasic();
    resetCtx();
    chain39(64'h5555, F_V | F_R | F_W | F_A | F_D);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R12 three-level addr", gotAddr, 64'h555_5456);
    checkEq("R5 three-level code", {61'd0, gotFault}, 64'd0);
    checkEq("R5 three-level reads", 64'(gotReads), 64'd3);
    rspDelay = 4;
    runWalk(VA39, T_S, 2'd2, 64'h100);
    checkEq("R14 slow memory addr", gotAddr, 64'h555_5456);
    checkEq("R14 slow memory code", {61'd0, gotFault}, 64'd0);
  endtask

  task automatic tBusyIgnore();
    int waitCnt;
    resetCtx();
    rspDelay = 3;
    chain39(64'h5555, F_V | F_R | F_W | F_A | F_D);
    @(negedge clk);
    reqCount = 0; startVa = VA39; startType = T_L; pageMode = 2'd2;
    rootPpn = 64'h100; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    checkEq("R1 busy after accept", {63'd0, busy}, 64'd1);
    @(negedge clk);
    startVa = 64'h1234; pageMode = 2'd0; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    waitCnt = 0;
    while (!doneValid && waitCnt < 300) begin
      @(negedge clk);
      waitCnt++;
    end
    checkEq("R1 ignored start addr", resultAddr, 64'h555_5456);
    checkEq("R1 ignored start reads", 64'(reqCount), 64'd3);
    @(negedge clk);
    checkEq("R1 done one cycle", {63'd0, doneValid}, 64'd0);
    checkEq("R1 idle after done", {63'd0, busy}, 64'd0);
  endtask

  task automatic tPrivilege();
    resetCtx();
    chain39(64'h5555, F_V | F_R | F_X | F_U | F_A);
    mprv = 1'b1; prevSup = 1'b0;
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R2 mprv user load", {61'd0, gotFault}, 64'd0);
    debugMode = 1'b1;
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R2 debug ignores mprv", {61'd0, gotFault}, 64'd2);
    debugMode = 1'b0;
    runWalk(VA39, T_F, 2'd2, 64'h100);
    checkEq("R2 fetch uses current", {61'd0, gotFault}, 64'd1);
    curSup = 1'b0; prevSup = 1'b1;
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R2 mprv supervisor load", {61'd0, gotFault}, 64'd2);
  endtask

  task automatic tUser();
    resetCtx();
    chain39(64'h5555, F_V | F_R | F_X | F_U | F_A);
    runWalk(VA39, T_F, 2'd2, 64'h100);
    checkEq("R7 sup fetch user page", {61'd0, gotFault}, 64'd1);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R7 sup load sum clear", {61'd0, gotFault}, 64'd2);
    sumBit = 1'b1;
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R7 sup load sum set", {61'd0, gotFault}, 64'd0);
    sumBit = 1'b0; curSup = 1'b0;
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R7 user load user page", {61'd0, gotFault}, 64'd0);
    chain39(64'h5555, F_V | F_R | F_A);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R7 user load sup page", {61'd0, gotFault}, 64'd2);
  endtask

  task automatic tForm();
    resetCtx();
    chain39(64'h5555, F_V | F_W | F_A | F_D);
    runWalk(VA39, T_S, 2'd2, 64'h100);
    checkEq("R8 write without read", {61'd0, gotFault}, 64'd3);
    chain39(64'h5555, F_R | F_W | F_A | F_D);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R8 invalid leaf", {61'd0, gotFault}, 64'd2);
  endtask

  task automatic tPerm();
    resetCtx();
    chain39(64'h5555, F_V | F_R | F_A | F_D);
    runWalk(VA39, T_S, 2'd2, 64'h100);
    checkEq("R9 store read-only", {61'd0, gotFault}, 64'd3);
    chain39(64'h5555, F_V | F_X | F_A);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R9 load exec-only mxr clear", {61'd0, gotFault}, 64'd2);
    mxrBit = 1'b1;
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R9 load exec-only mxr set", {61'd0, gotFault}, 64'd0);
    mxrBit = 1'b0;
    chain39(64'h5555, F_V | F_R | F_W | F_A | F_D);
    runWalk(VA39, T_F, 2'd2, 64'h100);
    checkEq("R9 fetch without X", {61'd0, gotFault}, 64'd1);
  endtask

  task automatic tAccessDirty();
    resetCtx();
    chain39(64'h5555, F_V | F_R | F_W | F_A);
    runWalk(VA39, T_S, 2'd2, 64'h100);
    checkEq("R11 store dirty clear", {61'd0, gotFault}, 64'd3);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R11 load dirty clear", {61'd0, gotFault}, 64'd0);
    chain39(64'h5555, F_V | F_R | F_W | F_D);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R11 load accessed clear", {61'd0, gotFault}, 64'd2);
  endtask

  task automatic tSuperpage();
    resetCtx();
    chain39(64'h5555, F_V | F_R | F_W | F_A | F_D);
    ptMem[64'h10_1010] = pteOf(64'h200, F_V | F_R | F_W | F_A | F_D);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R12 superpage addr", gotAddr, 64'h20_3456);
    checkEq("R12 superpage reads", 64'(gotReads), 64'd2);
    ptMem[64'h10_1010] = pteOf(64'h201, F_V | F_R | F_W | F_A | F_D);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R10 misaligned superpage", {61'd0, gotFault}, 64'd2);
  endtask

  task automatic tPointerLast();
    resetCtx();
    chain39(64'h55, F_V);
    runWalk(VA39, T_L, 2'd2, 64'h100);
    checkEq("R6 pointer at level 0", {61'd0, gotFault}, 64'd2);
    checkEq("R6 pointer at level 0 reads", 64'(gotReads), 64'd3);
  endtask

  task automatic tCanon();
    resetCtx();
    chain39(64'h5555, F_V | F_R | F_W | F_A | F_D);
    runWalk(64'h0000_8000_0000_0000, T_S, 2'd2, 64'h100);
    checkEq("R4 non-canonical code", {61'd0, gotFault}, 64'd3);
    checkEq("R4 non-canonical reads", 64'(gotReads), 64'd0);
    runWalk(64'hFFFF_FFC0_4040_3456, T_L, 2'd2, 64'h100);
    checkEq("R13 canonical high, missing root entry", {61'd0, gotFault}, 64'd6);
    checkEq("R13 one read", 64'(gotReads), 64'd1);
  endtask

  task automatic tAccess();
    resetCtx();
    chain39(64'h5555, F_V | F_R | F_W | F_A | F_D);
    ptMem[64'h10_1010] = pteOf(64'h999, F_V);
    runWalk(VA39, T_F, 2'd2, 64'h100);
    checkEq("R13 fetch access fault", {61'd0, gotFault}, 64'd5);
    checkEq("R13 fetch access reads", 64'(gotReads), 64'd3);
    runWalk(VA39, T_S, 2'd2, 64'h100);
    checkEq("R13 store access fault", {61'd0, gotFault}, 64'd7);
  endtask

  task automatic tModes();
    resetCtx();
    ptMem.delete();
    ptMem[64'h30_0014] = 64'hFFFF_FFFF_0000_0000 | pteOf(64'h301, F_V);
    ptMem[64'h30_101C] = 64'hABCD_0000_0000_0000 | pteOf(64'h777, F_V | F_X | F_A);
    runWalk(64'h0140_7123, T_F, 2'd1, 64'h300);
    checkEq("R5 two-level addr", gotAddr, 64'h77_7123);
    checkEq("R5 two-level reads", 64'(gotReads), 64'd2);
    ptMem.delete();
    ptMem[64'h40_0000] = pteOf(64'h401, F_V);
    ptMem[64'h40_1000] = pteOf(64'h402, F_V);
    ptMem[64'h40_2000] = pteOf(64'h403, F_V);
    ptMem[64'h40_3008] = pteOf(64'h42, F_V | F_R | F_A | F_D);
    runWalk(64'h1ABC, T_L, 2'd3, 64'h400);
    checkEq("R5 four-level addr", gotAddr, 64'h4_2ABC);
    checkEq("R6 four-level reads", 64'(gotReads), 64'd4);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL R1 watchdog: actual hung expected finished");
    checkCount++;
    failCount++;
    report();
    $finish;
  end

  initial begin
    rstN = 1'b0; startValid = 1'b0; startVa = '0; startType = '0;
    pageMode = '0; rootPpn = '0;
    resetCtx();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tBare();
    tBasic();
    tBusyIgnore();
    tPrivilege();
    tUser();
    tForm();
    tPerm();
    tAccessDirty();
    tSuperpage();
    tPointerLast();
    tCanon();
    tAccess();
    tModes();
    checkEq("R14 one outstanding read", 64'(protoErr), 64'd0);
    report();
    $finish;
  end

endmodule